// File: doc/BRIEF.md
# Inverting Bidirectional Latched Transceiver

This block carries data between two 8-bit ports, A and B, one direction at a time or both at once. Each direction has its own bank of storage latches and three active-low controls: a direction enable, a latch enable and an output enable. Data is complemented on the way through in both directions, so a port never shows the true value it was given, only its inverse.

A direction loads its bank only while its direction enable and its latch enable are both low. While loading, the bank is transparent: the far port follows the near port combinationally. Raising the latch enable freezes the bank on the value seen at the last clock edge of the open window. The far port is driven only while the direction enable and the output enable are both low. Each port is split into an input vector, an output vector and a per-bit output-enable vector, so no tri-state logic sits inside the block. A pad wrapper can add real tri-state buffers later. Each port also has a contention flag. It rises when the block drives the port while the outside world says it is driving the same port.

The latch banks are built as clocked storage that is updated on every clock edge while the bank is open. A combinational bypass gives the transparent path. A synchronous active-low reset clears both banks to zero.

Top module: `inv_latched_xcvr`

## Requirements
- R1: After reset, both banks hold 0x00. Port outputs then read 0xFF, and both output-enable vectors are 0x00 while every control is high.
- R2: While the A-to-B enable and the A-to-B latch enable are both low, b_out equals the bitwise complement of a_in in the same cycle, with no clock edge needed.
- R3: While the A-to-B enable is high, a_in has no effect on the A-to-B bank, even with its latch enable low. b_out keeps showing the complement of the held value.
- R4: When the A-to-B latch enable rises, the bank keeps the a_in value present at the last clock edge while the bank was open. Later changes on a_in leave b_out at the complement of that value.
- R5: b_oe is 0xFF exactly when the A-to-B enable and the A-to-B output enable are both low. Otherwise b_oe is 0x00.
- R6: The B-to-A direction behaves like R2 to R5, using its own three controls, with b_in as the source and a_out and a_oe as the destination.
- R7: The two banks are independent. Loading one direction leaves the value held by the other unchanged.
- R8: Toggling an output enable changes only the matching output-enable vector. It never changes the held value.
- R9: a_clash is 1 exactly when a_oe is nonzero and a_ext_drv is 1. b_clash is 1 exactly when b_oe is nonzero and b_ext_drv is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that updates the latch banks |
| rst_n | input | 1 | Synchronous active-low reset, clears both banks |
| a_in | input | 8 | Data arriving on port A |
| a_out | output | 8 | Complement of the B-to-A bank view, for port A |
| a_oe | output | 8 | Per-bit drive enable for port A |
| b_in | input | 8 | Data arriving on port B |
| b_out | output | 8 | Complement of the A-to-B bank view, for port B |
| b_oe | output | 8 | Per-bit drive enable for port B |
| ab_en_n | input | 1 | A-to-B direction enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_en_n | input | 1 | B-to-A direction enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_ext_drv | input | 1 | Outside agent is driving port A |
| b_ext_drv | input | 1 | Outside agent is driving port B |
| a_clash | output | 1 | Block and outside agent both drive port A |
| b_clash | output | 1 | Block and outside agent both drive port B |

## Verification
A bank that captures at the wrong moment shows up as a wrong complement on the far port. It appears in the first sample after the latch enable rises. The port output always shows the bank view whether or not it is driven, so a bank that leaks while disabled is visible before any output enable is asserted. A missing inversion or a swapped direction shows up in the same cycle as the data change, because the transparent path is combinational. A crossed drive gate shows up at once on the output-enable vector or on the clash flag.

// File: rtl/xcvr_pkg.sv
// Shared constants for the inverting latched transceiver.
// Assumes two transfer directions, indexed by dir_e.
package xcvr_pkg;
    localparam int DATA_W  = 8;
    localparam int NUM_DIR = 2;

    typedef enum logic {
        DIR_AB = 1'b0,
        DIR_BA = 1'b1
    } dir_e;
endpackage

// File: rtl/xcvr_lane.sv
// One transfer direction: a bank of level-gated storage plus output control.
// The bank is loaded on each clock edge while en_n and le_n are both low.
// While open, the output follows the source combinationally.
// The output is always the complement of the bank view.
// Assumes rst_n is synchronous and active low.
module xcvr_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_in,
    input  logic         en_n,
    input  logic         le_n,
    input  logic         oe_n,
    output logic [W-1:0] dst_out,
    output logic [W-1:0] dst_oe
);
    logic         open_win;
    logic         drive;
    logic [W-1:0] store;
    logic [W-1:0] view;

    // Decide whether the bank is open and whether the far port is driven.
    always_comb begin
        open_win = ~en_n & ~le_n;
        drive    = ~en_n & ~oe_n;
    end

    // Update the bank while it is open; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        store <= '0;
        else if (open_win) store <= src_in;
    end

    // Pick the live source when open, the held value otherwise, and invert it.
    always_comb begin
        view    = open_win ? src_in : store;
        dst_out = ~view;
    end

    // Fan the single drive decision out to every bit.
    generate
        for (genvar i = 0; i < W; i++) begin : g_oe
            assign dst_oe[i] = drive;
        end
    endgenerate

    // Bank keeps its value while the direction is disabled.
    assert_hold_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> (store == $past(store)));

    // Bank captures the source seen at an edge of the open window.
    assert_capture_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !le_n) |=> (store == $past(src_in)));

    // With the latch closed for two edges, the output cannot move.
    assert_closed_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (le_n && $past(le_n)) |-> $stable(dst_out));
endmodule

// File: rtl/xcvr_clash.sv
// Contention detector for one port.
// Flags when the block drives any bit while the outside agent also drives.
module xcvr_clash #(
    parameter int W = 8
) (
    input  logic [W-1:0] own_oe,
    input  logic         ext_drv,
    output logic         clash
);
    // Combine the block's drive with the outside drive indication.
    always_comb clash = (|own_oe) & ext_drv;
endmodule

// File: rtl/inv_latched_xcvr.sv
// Inverting bidirectional latched transceiver top.
// Two independent lanes (A to B, B to A), each with its own controls.
// There is a contention flag per port.
// Ports are split into in, out and per-bit drive enable vectors.
module inv_latched_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    input  logic         ab_en_n,
    input  logic         ab_le_n,
    input  logic         ab_oe_n,
    input  logic         ba_en_n,
    input  logic         ba_le_n,
    input  logic         ba_oe_n,
    input  logic         a_ext_drv,
    input  logic         b_ext_drv,
    output logic         a_clash,
    output logic         b_clash
);
    logic [NUM_DIR-1:0][W-1:0] src, dout, doe;
    logic [NUM_DIR-1:0]        en_n, le_n, oe_n, ext, clash;

    // Route port-level signals into per-direction arrays.
    always_comb begin
        src[DIR_AB]  = a_in;      src[DIR_BA]  = b_in;
        en_n[DIR_AB] = ab_en_n;   en_n[DIR_BA] = ba_en_n;
        le_n[DIR_AB] = ab_le_n;   le_n[DIR_BA] = ba_le_n;
        oe_n[DIR_AB] = ab_oe_n;   oe_n[DIR_BA] = ba_oe_n;
        ext[DIR_AB]  = b_ext_drv; ext[DIR_BA]  = a_ext_drv;
    end

    generate
        for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
            xcvr_lane #(.W(W)) u_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .src_in (src[d]),
                .en_n   (en_n[d]),
                .le_n   (le_n[d]),
                .oe_n   (oe_n[d]),
                .dst_out(dout[d]),
                .dst_oe (doe[d])
            );
            xcvr_clash #(.W(W)) u_clash (
                .own_oe (doe[d]),
                .ext_drv(ext[d]),
                .clash  (clash[d])
            );
        end
    endgenerate

    // Map lane results back onto the destination ports.
    always_comb begin
        b_out   = dout[DIR_AB];  b_oe = doe[DIR_AB];  b_clash = clash[DIR_AB];
        a_out   = dout[DIR_BA];  a_oe = doe[DIR_BA];  a_clash = clash[DIR_BA];
    end

    // Transparent A to B path shows the inverted source.
    assert_ab_transparent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_en_n && !ab_le_n) |-> (b_out == ~a_in));

    // Transparent B to A path shows the inverted source.
    assert_ba_transparent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_en_n && !ba_le_n) |-> (a_out == ~b_in));

    // Port B drive is all or nothing, and only with both enables low.
    assert_b_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe != '0) |-> (!ab_en_n && !ab_oe_n && (&b_oe)));

    // A clash on port A needs an outside driver.
    assert_a_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
        a_clash |-> (a_ext_drv && (a_oe != '0)));
endmodule

// File: tb/inv_latched_xcvr_test.sv
module inv_latched_xcvr_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic         ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n;
    logic         a_ext_drv, b_ext_drv, a_clash, b_clash;
    int           checks = 0;
    int           errors = 0;
    bit           done   = 1'b0;

    always #4 clk = ~clk;

    inv_latched_xcvr #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
        .a_ext_drv(a_ext_drv), .b_ext_drv(b_ext_drv),
        .a_clash(a_clash), .b_clash(b_clash)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Drive inputs mid-cycle, away from the rising edge.
    task automatic at_neg;
        @(negedge clk);
    endtask

    // Open the A-to-B bank on a value across one edge, then close it.
    task automatic load_ab(input logic [W-1:0] v);
        at_neg; ab_en_n = 0; ab_le_n = 0; a_in = v;
        at_neg; ab_le_n = 1;
    endtask

    // Open the B-to-A bank on a value across one edge, then close it.
    task automatic load_ba(input logic [W-1:0] v);
        at_neg; ba_en_n = 0; ba_le_n = 0; b_in = v;
        at_neg; ba_le_n = 1;
    endtask

    task automatic t_reset;
        at_neg; #1;
        check("R1 b_out", b_out, 8'hFF);
        check("R1 a_out", a_out, 8'hFF);
        check("R1 b_oe", b_oe, 8'h00);
        check("R1 a_oe", a_oe, 8'h00);
    endtask

    task automatic t_transparent;
        at_neg; ab_en_n = 0; ab_le_n = 0; a_in = 8'h5A; #1;
        check("R2 follow 5A", b_out, 8'hA5);
        a_in = 8'h0F; #1;
        check("R2 follow 0F", b_out, 8'hF0);
        ab_le_n = 1;
    endtask

    task automatic t_store;
        load_ab(8'h3C);
        a_in = 8'hFF; #1;
        check("R4 held after close", b_out, 8'hC3);
        at_neg; a_in = 8'h81; at_neg; #1;
        check("R4 held later", b_out, 8'hC3);
    endtask

    task automatic t_disabled;
        at_neg; ab_en_n = 1; ab_le_n = 0; a_in = 8'h55;
        at_neg; at_neg; #1;
        check("R3 ignore while disabled", b_out, 8'hC3);
        ab_le_n = 1;
        at_neg; ab_en_n = 0; #1;
        check("R3 kept after enable", b_out, 8'hC3);
    endtask

    task automatic t_drive;
        at_neg; ab_en_n = 0; ab_oe_n = 1; #1;
        check("R5 oe high", b_oe, 8'h00);
        ab_oe_n = 0; #1;
        check("R5 both low", b_oe, 8'hFF);
        ab_en_n = 1; #1;
        check("R5 en high", b_oe, 8'h00);
        ab_en_n = 0;
    endtask

    task automatic t_oe_no_effect;
        at_neg; ab_oe_n = 1; at_neg; ab_oe_n = 0; at_neg; #1;
        check("R8 value after oe toggle", b_out, 8'hC3);
    endtask

    task automatic t_reverse;
        load_ba(8'h96);
        b_in = 8'h00; #1;
        check("R6 ba held", a_out, 8'h69);
        ba_oe_n = 0; #1;
        check("R6 ba drive", a_oe, 8'hFF);
        check("R7 ab untouched", b_out, 8'hC3);
        load_ab(8'h12); #1;
        check("R7 ba untouched", a_out, 8'h69);
        check("R7 ab new", b_out, 8'hED);
    endtask

    task automatic t_clash;
        at_neg; b_ext_drv = 1; #1;
        check("R9 b clash", {7'b0, b_clash}, 8'h01);
        ab_oe_n = 1; #1;
        check("R9 b no drive", {7'b0, b_clash}, 8'h00);
        a_ext_drv = 1; #1;
        check("R9 a clash", {7'b0, a_clash}, 8'h01);
        a_ext_drv = 0; #1;
        check("R9 a quiet", {7'b0, a_clash}, 8'h00);
    endtask

    initial begin
        rst_n = 0; a_in = '0; b_in = '0;
        ab_en_n = 1; ab_le_n = 1; ab_oe_n = 1;
        ba_en_n = 1; ba_le_n = 1; ba_oe_n = 1;
        a_ext_drv = 0; b_ext_drv = 0;
        repeat (3) @(posedge clk);
        at_neg; rst_n = 1;
        t_reset;
        t_transparent;
        t_store;
        t_disabled;
        t_drive;
        t_oe_no_effect;
        t_reverse;
        t_clash;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(8 * 200000);
                errors++;
                checks++;
                $display("FAIL watchdog expired got=1 exp=0");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule